// File: doc/BRIEF.md
# USB Endpoint Control Register Bank

This block holds the software-visible control and status state for the endpoints of a full-speed USB device controller. There is one 16-bit register per endpoint. It also holds a buffer-table base register and a 7-bit device address. Software reaches these registers over a plain synchronous register bus. The packet engine reports completed transfers, setup packets and data-toggle advances through single-cycle pulse inputs. A separate input signals a bus reset, whether it is detected on the wire or forced.

The fields of an endpoint register follow different write rules:
- The transfer-complete flags can only be cleared by software.
- The data toggles and the handshake status fields flip when software writes a 1.
- The setup flag is owned by hardware.
- The type, kind and endpoint number fields are ordinary storage.

A bus reset clears endpoint state, but it keeps the transfer-complete flags, so a completion reported just before the reset is not lost.

For each incoming token, the bank compares the token's device address and endpoint number against its own registers. It reports the lowest-numbered endpoint that matches, together with a valid flag.

Top module: `usb_ep_bank`

## Requirements
- R1: After the synchronous reset `rst`, every endpoint register, the buffer-table base and the device address read 0. This includes both transfer-complete flags. `reg_rdata` is 0.
- R2: Byte offset 4*i (i < N_EP) selects endpoint register i, offset 0x4C selects the device address and offset 0x50 selects the buffer-table base. Read data appears on `reg_rdata` in the cycle after `reg_re` and holds until the next read.
- R3: In an endpoint register, bit 15 (receive complete) and bit 7 (transmit complete) are set by `hw_rx_done[i]` and `hw_tx_done[i]`. A software write of 0 clears them and a write of 1 leaves them as they are. A hardware set in the same cycle as a software clear leaves the bit set.
- R4: Bits 14 and 6 (receive and transmit data toggle) and the status pairs 13:12 and 5:4 invert where software writes 1 and keep their value where it writes 0. `hw_rx_tgl[i]` and `hw_tx_tgl[i]` invert bits 14 and 6. A software toggle and a hardware toggle of the same bit in one cycle cancel.
- R5: Bit 11 (setup) ignores software writes. On each `hw_rx_done[i]` pulse, bit 11 takes the value of `hw_rx_setup`.
- R6: Bits 10:9 (type), bit 8 (kind) and bits 3:0 (endpoint number) store the written value.
- R7: In the buffer-table base, bits 15:3 store the written value and bits 2:0 always read 0. A bus reset leaves this register unchanged.
- R8: Bits 6:0 of the device address register store the written value and bits 15:7 read 0.
- R9: A `bus_rst` pulse clears every endpoint field except bits 15 and 7, and it also clears the device address. It takes priority over software writes and hardware toggles to those fields in the same cycle.
- R10: Reads of any other offset, including misaligned ones, return 0. Writes to them change no register.
- R11: `match_valid` is 1 only when `tok_valid` is 1, `tok_dev_addr` equals the device address and `tok_ep_num` equals some endpoint's bits 3:0. `match_idx` is then the lowest such endpoint. Both outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all state |
| bus_rst | input | 1 | One-cycle USB bus reset (detected or forced) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write enable |
| reg_re | input | 1 | Read enable |
| reg_rdata | output | 16 | Registered read data |
| hw_rx_done | input | N_EP | Per-endpoint receive-complete pulse |
| hw_rx_setup | input | 1 | Qualifies a receive-complete pulse as a setup packet |
| hw_tx_done | input | N_EP | Per-endpoint transmit-complete pulse |
| hw_rx_tgl | input | N_EP | Per-endpoint receive data-toggle advance |
| hw_tx_tgl | input | N_EP | Per-endpoint transmit data-toggle advance |
| tok_valid | input | 1 | Token fields are valid |
| tok_dev_addr | input | 7 | Device address of the token |
| tok_ep_num | input | 4 | Endpoint number of the token |
| match_valid | output | 1 | An endpoint matches the token |
| match_idx | output | IDX_W | Lowest matching endpoint index |

## Verification
The properties assume the following about the inputs:
- `bus_rst` and the hardware event inputs are known, synchronous, one-cycle pulses.
- `reg_addr` is stable during a write or read.
- Token fields are only meaningful while `tok_valid` is high.

The stimulus drives every input on the falling edge with defined values. It raises each event for exactly one cycle, and it reads results only on the falling edge after the capturing rising edge. It deliberately lines up a hardware set with a software clear, and a hardware toggle with a software toggle, so that the priority and cancellation rules are exercised within those assumptions.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

    localparam int REG_W     = 16;
    localparam int EPNUM_W   = 4;
    localparam int DADDR_W   = 7;
    localparam int BT_LSB    = 3;
    localparam int OFS_DADDR = 'h4C;
    localparam int OFS_BTBL  = 'h50;

    // Endpoint register image; field order fixes the software bit positions.
    typedef struct packed {
        logic       rx_done;   // 15
        logic       rx_tog;    // 14
        logic [1:0] rx_stat;   // 13:12
        logic       setup;     // 11
        logic [1:0] ep_type;   // 10:9
        logic       ep_kind;   // 8
        logic       tx_done;   // 7
        logic       tx_tog;    // 6
        logic [1:0] tx_stat;   // 5:4
        logic [3:0] ep_num;    // 3:0
    } ep_reg_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_EP,
        SEL_DADDR,
        SEL_BTBL
    } reg_sel_e;

    // Completion flag: hardware set dominates, software may only clear.
    function automatic logic done_next(input logic cur, input logic wr,
                                       input logic wbit, input logic hw_set);
        if (hw_set)
            return 1'b1;
        else if (wr && !wbit)
            return 1'b0;
        return cur;
    endfunction

    // Toggle field: each written 1 inverts the matching bit.
    function automatic logic [1:0] flip2(input logic [1:0] cur, input logic wr,
                                         input logic [1:0] wbits);
        return wr ? (cur ^ wbits) : cur;
    endfunction

endpackage

// File: rtl/usb_ep_reg.sv
module usb_ep_reg
    import usb_ep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bus_rst,
    input  logic    wr_en,
    input  ep_reg_t wdata,
    input  logic    hw_rx_done,
    input  logic    hw_rx_setup,
    input  logic    hw_tx_done,
    input  logic    hw_rx_tgl,
    input  logic    hw_tx_tgl,
    output ep_reg_t q
);

    ep_reg_t q_r;
    ep_reg_t d;

    always_comb begin
        d = q_r;
        d.rx_done = done_next(q_r.rx_done, wr_en, wdata.rx_done, hw_rx_done);
        d.tx_done = done_next(q_r.tx_done, wr_en, wdata.tx_done, hw_tx_done);
        if (bus_rst) begin
            d.rx_tog  = 1'b0;
            d.rx_stat = '0;
            d.setup   = 1'b0;
            d.ep_type = '0;
            d.ep_kind = 1'b0;
            d.tx_tog  = 1'b0;
            d.tx_stat = '0;
            d.ep_num  = '0;
        end else begin
            d.rx_tog  = q_r.rx_tog ^ (wr_en & wdata.rx_tog) ^ hw_rx_tgl;
            d.tx_tog  = q_r.tx_tog ^ (wr_en & wdata.tx_tog) ^ hw_tx_tgl;
            d.rx_stat = flip2(q_r.rx_stat, wr_en, wdata.rx_stat);
            d.tx_stat = flip2(q_r.tx_stat, wr_en, wdata.tx_stat);
            if (wr_en) begin
                d.ep_type = wdata.ep_type;
                d.ep_kind = wdata.ep_kind;
                d.ep_num  = wdata.ep_num;
            end
            if (hw_rx_done)
                d.setup = hw_rx_setup;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= '0;
        else
            q_r <= d;
    end

    assign q = q_r;

endmodule

// File: rtl/usb_ep_decode.sv
module usb_ep_decode
    import usb_ep_pkg::*;
#(
    parameter int N_EP   = 8,
    parameter int ADDR_W = 7,
    localparam int IDX_W = (N_EP > 1) ? $clog2(N_EP) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [N_EP-1:0]   ep_hit,
    output logic [IDX_W-1:0]  ep_idx
);

    logic       in_ep_window;
    logic [2:0] slot;

    assign slot         = addr[4:2];
    assign in_ep_window = ((addr >> 5) == '0) && (addr[1:0] == 2'b00);
    assign ep_idx       = slot[IDX_W-1:0];

    for (genvar g = 0; g < N_EP; g++) begin : g_hit
        assign ep_hit[g] = in_ep_window && (slot == 3'(g));
    end

    always_comb begin
        sel = SEL_NONE;
        if (|ep_hit)
            sel = SEL_EP;
        else if (addr == ADDR_W'(OFS_DADDR))
            sel = SEL_DADDR;
        else if (addr == ADDR_W'(OFS_BTBL))
            sel = SEL_BTBL;
    end

endmodule

// File: rtl/usb_ep_match.sv
module usb_ep_match
    import usb_ep_pkg::*;
#(
    parameter int N_EP = 8,
    localparam int IDX_W = (N_EP > 1) ? $clog2(N_EP) : 1
) (
    input  logic                      tok_valid,
    input  logic [DADDR_W-1:0]        tok_dev_addr,
    input  logic [EPNUM_W-1:0]        tok_ep_num,
    input  logic [DADDR_W-1:0]        dev_addr,
    input  logic [N_EP*EPNUM_W-1:0]   ep_nums,
    output logic                      match_valid,
    output logic [IDX_W-1:0]          match_idx
);

    logic             addr_ok;
    logic [N_EP-1:0]  hit;

    assign addr_ok = tok_valid && (tok_dev_addr == dev_addr);

    for (genvar g = 0; g < N_EP; g++) begin : g_cmp
        assign hit[g] = addr_ok && (ep_nums[g*EPNUM_W +: EPNUM_W] == tok_ep_num);
    end

    // Scan from the top so the lowest index is the last to win.
    always_comb begin
        match_valid = 1'b0;
        match_idx   = '0;
        for (int i = N_EP - 1; i >= 0; i--) begin
            if (hit[i]) begin
                match_valid = 1'b1;
                match_idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/usb_ep_bank.sv
module usb_ep_bank
    import usb_ep_pkg::*;
#(
    parameter int N_EP   = 8,
    parameter int ADDR_W = 7,
    localparam int IDX_W = (N_EP > 1) ? $clog2(N_EP) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic                reg_we,
    input  logic                reg_re,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [N_EP-1:0]     hw_rx_done,
    input  logic                hw_rx_setup,
    input  logic [N_EP-1:0]     hw_tx_done,
    input  logic [N_EP-1:0]     hw_rx_tgl,
    input  logic [N_EP-1:0]     hw_tx_tgl,
    input  logic                tok_valid,
    input  logic [DADDR_W-1:0]  tok_dev_addr,
    input  logic [EPNUM_W-1:0]  tok_ep_num,
    output logic                match_valid,
    output logic [IDX_W-1:0]    match_idx
);

    reg_sel_e                   sel;
    logic [N_EP-1:0]            ep_hit;
    logic [IDX_W-1:0]           ep_idx;
    ep_reg_t                    ep_q [N_EP];
    logic [N_EP*REG_W-1:0]      ep_flat;
    logic [N_EP*EPNUM_W-1:0]    ep_nums;
    logic [DADDR_W-1:0]         dev_addr_q;
    logic [REG_W-1:BT_LSB]      btbl_q;
    logic [REG_W-1:0]           rd_mux;
    logic [REG_W-1:0]           rdata_q;

    usb_ep_decode #(.N_EP(N_EP), .ADDR_W(ADDR_W)) decode_i (
        .addr   (reg_addr),
        .sel    (sel),
        .ep_hit (ep_hit),
        .ep_idx (ep_idx)
    );

    for (genvar g = 0; g < N_EP; g++) begin : g_ep
        usb_ep_reg ep_i (
            .clk         (clk),
            .rst         (rst),
            .bus_rst     (bus_rst),
            .wr_en       (reg_we && ep_hit[g]),
            .wdata       (ep_reg_t'(reg_wdata)),
            .hw_rx_done  (hw_rx_done[g]),
            .hw_rx_setup (hw_rx_setup),
            .hw_tx_done  (hw_tx_done[g]),
            .hw_rx_tgl   (hw_rx_tgl[g]),
            .hw_tx_tgl   (hw_tx_tgl[g]),
            .q           (ep_q[g])
        );
        assign ep_flat[g*REG_W +: REG_W]     = ep_q[g];
        assign ep_nums[g*EPNUM_W +: EPNUM_W] = ep_q[g].ep_num;
    end

    always_ff @(posedge clk) begin
        if (rst || bus_rst)
            dev_addr_q <= '0;
        else if (reg_we && sel == SEL_DADDR)
            dev_addr_q <= reg_wdata[DADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            btbl_q <= '0;
        else if (reg_we && sel == SEL_BTBL)
            btbl_q <= reg_wdata[REG_W-1:BT_LSB];
    end

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_EP:    rd_mux = ep_flat[int'(ep_idx)*REG_W +: REG_W];
            SEL_DADDR: rd_mux = {{(REG_W-DADDR_W){1'b0}}, dev_addr_q};
            SEL_BTBL:  rd_mux = {btbl_q, {BT_LSB{1'b0}}};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (reg_re)
            rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;

    usb_ep_match #(.N_EP(N_EP)) match_i (
        .tok_valid    (tok_valid),
        .tok_dev_addr (tok_dev_addr),
        .tok_ep_num   (tok_ep_num),
        .dev_addr     (dev_addr_q),
        .ep_nums      (ep_nums),
        .match_valid  (match_valid),
        .match_idx    (match_idx)
    );

endmodule

// File: rtl/usb_ep_bank_chk.sv
module usb_ep_bank_chk
    import usb_ep_pkg::*;
#(
    parameter int N_EP   = 8,
    parameter int ADDR_W = 7,
    localparam int IDX_W = (N_EP > 1) ? $clog2(N_EP) : 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_rst,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [REG_W-1:0]         reg_wdata,
    input logic                     reg_we,
    input logic                     reg_re,
    input logic [REG_W-1:0]         reg_rdata,
    input logic [N_EP-1:0]          hw_rx_done,
    input logic [N_EP-1:0]          hw_tx_done,
    input logic                     tok_valid,
    input logic [EPNUM_W-1:0]       tok_ep_num,
    input logic                     match_valid,
    input logic [IDX_W-1:0]         match_idx,
    input logic [N_EP*REG_W-1:0]    ep_flat
);

    logic unmapped;
    assign unmapped = (reg_addr[1:0] != 2'b00) ||
                      ((reg_addr >= ADDR_W'(4 * N_EP)) &&
                       (reg_addr != ADDR_W'(OFS_DADDR)) &&
                       (reg_addr != ADDR_W'(OFS_BTBL)));

    assert_match_needs_tok_R11: assert property (@(posedge clk) disable iff (rst)
        !tok_valid |-> !match_valid);

    assert_match_epnum_R11: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> (ep_flat[int'(match_idx)*REG_W +: EPNUM_W] == tok_ep_num));

    assert_btbl_align_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_re && reg_addr == ADDR_W'(OFS_BTBL)) |=> (reg_rdata[BT_LSB-1:0] == '0));

    assert_daddr_upper_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_re && reg_addr == ADDR_W'(OFS_DADDR)) |=> (reg_rdata[REG_W-1:DADDR_W] == '0));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_re && unmapped) |=> (reg_rdata == '0));

    for (genvar g = 0; g < N_EP; g++) begin : g_ep_chk
        assert_rx_set_R3: assert property (@(posedge clk) disable iff (rst)
            hw_rx_done[g] |=> ep_flat[g*REG_W + 15]);

        assert_tx_set_R3: assert property (@(posedge clk) disable iff (rst)
            hw_tx_done[g] |=> ep_flat[g*REG_W + 7]);

        assert_w1_keeps_R3: assert property (@(posedge clk) disable iff (rst)
            (reg_we && reg_addr == ADDR_W'(4 * g) && reg_wdata[15] && ep_flat[g*REG_W + 15])
            |=> ep_flat[g*REG_W + 15]);

        assert_bus_rst_clears_R9: assert property (@(posedge clk) disable iff (rst)
            bus_rst |=> ((ep_flat[g*REG_W +: REG_W] & 16'h7F7F) == 16'h0000));
    end

endmodule

bind usb_ep_bank usb_ep_bank_chk #(.N_EP(N_EP), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_rst     (bus_rst),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_we      (reg_we),
    .reg_re      (reg_re),
    .reg_rdata   (reg_rdata),
    .hw_rx_done  (hw_rx_done),
    .hw_tx_done  (hw_tx_done),
    .tok_valid   (tok_valid),
    .tok_ep_num  (tok_ep_num),
    .match_valid (match_valid),
    .match_idx   (match_idx),
    .ep_flat     (ep_flat)
);

// File: tb/usb_ep_bank_tb.sv
module usb_ep_bank_tb_top;

    localparam int N_EP   = 8;
    localparam int ADDR_W = 7;
    localparam int IDX_W  = 3;
    localparam int NVEC   = 16;

    // {write(1)/read-check(0), offset[6:0], wdata[15:0], expected[15:0]}
    localparam logic [39:0] VEC [NVEC] = '{
        {1'b0, 7'h00, 16'h0000, 16'h0000},  // R1 reset value
        {1'b1, 7'h00, 16'h7675, 16'h0000},  // R4 R6 first write
        {1'b0, 7'h00, 16'h0000, 16'h7675},
        {1'b1, 7'h00, 16'h5061, 16'h0000},  // R4 toggles back, R6 overwrite
        {1'b0, 7'h00, 16'h0000, 16'h2011},
        {1'b1, 7'h50, 16'hFFFF, 16'h0000},  // R7
        {1'b0, 7'h50, 16'h0000, 16'hFFF8},
        {1'b1, 7'h4C, 16'hFFFF, 16'h0000},  // R8
        {1'b0, 7'h4C, 16'h0000, 16'h007F},
        {1'b1, 7'h1C, 16'h0709, 16'h0000},  // R2 last endpoint slot
        {1'b0, 7'h1C, 16'h0000, 16'h0709},
        {1'b1, 7'h20, 16'hFFFF, 16'h0000},  // R10 unmapped
        {1'b1, 7'h1D, 16'hFFFF, 16'h0000},  // R10 misaligned
        {1'b0, 7'h20, 16'h0000, 16'h0000},
        {1'b0, 7'h00, 16'h0000, 16'h2011},
        {1'b0, 7'h1C, 16'h0000, 16'h0709}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_rst = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [15:0]       reg_wdata = '0;
    logic              reg_we = 1'b0;
    logic              reg_re = 1'b0;
    logic [15:0]       reg_rdata;
    logic [N_EP-1:0]   hw_rx_done = '0;
    logic              hw_rx_setup = 1'b0;
    logic [N_EP-1:0]   hw_tx_done = '0;
    logic [N_EP-1:0]   hw_rx_tgl = '0;
    logic [N_EP-1:0]   hw_tx_tgl = '0;
    logic              tok_valid = 1'b0;
    logic [6:0]        tok_dev_addr = '0;
    logic [3:0]        tok_ep_num = '0;
    logic              match_valid;
    logic [IDX_W-1:0]  match_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    usb_ep_bank #(.N_EP(N_EP), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .bus_rst(bus_rst),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata),
        .hw_rx_done(hw_rx_done), .hw_rx_setup(hw_rx_setup),
        .hw_tx_done(hw_tx_done), .hw_rx_tgl(hw_rx_tgl), .hw_tx_tgl(hw_tx_tgl),
        .tok_valid(tok_valid), .tok_dev_addr(tok_dev_addr), .tok_ep_num(tok_ep_num),
        .match_valid(match_valid), .match_idx(match_idx)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [6:0] a, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        check(req, reg_rdata, exp);
    endtask

    task automatic clear_hw();
        hw_rx_done = '0; hw_tx_done = '0; hw_rx_tgl = '0; hw_tx_tgl = '0;
        hw_rx_setup = 1'b0; bus_rst = 1'b0; reg_we = 1'b0;
    endtask

    task automatic tok(input string req, input logic v, input logic [6:0] da,
                       input logic [3:0] ep, input logic exp_v, input logic [2:0] exp_i);
        @(negedge clk);
        tok_valid = v; tok_dev_addr = da; tok_ep_num = ep;
        #2;
        check(req, {15'b0, match_valid}, {15'b0, exp_v});
        if (exp_v)
            check(req, {13'b0, match_idx}, {13'b0, exp_i});
        tok_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rdata after reset", reg_rdata, 16'h0000);
        #2;
        check("R1 R11 no match at rest", {15'b0, match_valid}, 16'h0000);

        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][39])
                wr(VEC[k][38:32], VEC[k][31:16]);
            else
                rd($sformatf("table vector %0d (R1 R2 R4 R6 R7 R8 R10)", k),
                   VEC[k][38:32], VEC[k][15:0]);
        end

        // R3 R5: receive completion of a setup packet on endpoint 2
        @(negedge clk); hw_rx_done[2] = 1'b1; hw_rx_setup = 1'b1;
        @(negedge clk); clear_hw();
        rd("R3 R5 rx done with setup", 7'h08, 16'h8800);
        wr(7'h08, 16'h8000);
        rd("R3 write 1 keeps flag", 7'h08, 16'h8800);
        wr(7'h08, 16'h0800);
        rd("R3 write 0 clears, R5 setup kept", 7'h08, 16'h0800);
        wr(7'h0C, 16'h0800);
        rd("R5 setup not writable", 7'h0C, 16'h0000);

        // R3: hardware set against software clear in the same cycle
        @(negedge clk); reg_addr = 7'h08; reg_wdata = 16'h0000; reg_we = 1'b1; hw_tx_done[2] = 1'b1;
        @(negedge clk); clear_hw();
        rd("R3 hw set beats sw clear", 7'h08, 16'h0880);

        // R4: colliding toggles cancel, lone hardware toggles invert
        @(negedge clk); reg_addr = 7'h10; reg_wdata = 16'h4000; reg_we = 1'b1; hw_rx_tgl[4] = 1'b1;
        @(negedge clk); clear_hw();
        rd("R4 sw and hw toggle cancel", 7'h10, 16'h0000);
        @(negedge clk); hw_rx_tgl[4] = 1'b1;
        @(negedge clk); clear_hw();
        rd("R4 hw rx toggle", 7'h10, 16'h4000);
        @(negedge clk); hw_tx_tgl[4] = 1'b1;
        @(negedge clk); clear_hw();
        rd("R4 hw tx toggle", 7'h10, 16'h4040);

        // R9: bus reset keeps only the completion flags
        wr(7'h04, 16'h7773);
        rd("R4 R6 endpoint 1 setup", 7'h04, 16'h7773);
        @(negedge clk); hw_rx_done[1] = 1'b1; hw_tx_done[1] = 1'b1;
        @(negedge clk); clear_hw();
        rd("R3 both flags set", 7'h04, 16'hF7F3);
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); clear_hw();
        rd("R9 endpoint 1 after bus reset", 7'h04, 16'h8080);
        rd("R9 endpoint 2 after bus reset", 7'h08, 16'h0080);
        rd("R9 device address cleared", 7'h4C, 16'h0000);
        rd("R7 buffer table kept", 7'h50, 16'hFFF8);

        // R11: token matching
        wr(7'h4C, 16'h0015);
        wr(7'h14, 16'h0006);
        wr(7'h18, 16'h0006);
        tok("R11 lowest of two matches", 1'b1, 7'h15, 4'h6, 1'b1, 3'd5);
        tok("R11 wrong device address", 1'b1, 7'h14, 4'h6, 1'b0, 3'd0);
        tok("R11 token not valid", 1'b0, 7'h15, 4'h6, 1'b0, 3'd0);
        tok("R11 no endpoint number match", 1'b1, 7'h15, 4'h9, 1'b0, 3'd0);
        tok("R11 many match picks 0", 1'b1, 7'h15, 4'h0, 1'b1, 3'd0);

        // R1: full reset clears completion flags too
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd("R1 flags cleared by reset", 7'h04, 16'h0000);
        rd("R1 buffer table cleared", 7'h50, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule